// File: doc/BRIEF.md
# Memory-Card Slot Status and Interrupt Register Block

This block is a small word-addressed register file that sits beside a memory-card slot. It returns two constant words, one that identifies the block and one that describes the address decode. A third word is reserved for flash programming: it reads as zero and ignores every write. The fourth word is the interrupt register, which combines the live level of the card's write-protect switch with a sticky flag that records a card insertion.

The interrupt output is driven straight from the sticky insertion flag. Software reads the interrupt register to find out why the line is raised. It acknowledges the insertion by writing the register with the flag's bit position set to one. Word indexes past the last implemented word read as zero and raise a one-cycle error pulse. The block does no card protocol handling.

Top module: `cdi_card_regs`

## Requirements
- R1: A read of word 0 returns 0x41034003, and a read of word 3 returns 0x00000011.
- R2: A read of word 1 returns zero. Writes to words 0, 1 and 3 change nothing that any later read or output shows.
- R3: Bit 0 of word 2 returns the `wp_in` level sampled in the access cycle. A write cannot change this bit.
- R4: If `card_in` is high at a clock edge, bit 3 of word 2 is set from the next cycle on. The bit stays set after `card_in` falls.
- R5: A write to word 2 whose data has bit 3 equal to 1 clears bit 3 in the next cycle. A write whose data has bit 3 equal to 0 leaves bit 3 unchanged.
- R6: `irq_out` always equals bit 3 of word 2. Bits other than 0 and 3 of word 2 read as zero.
- R7: When a clearing write to word 2 lands while `card_in` is high, bit 3 reads 0 for exactly one cycle and is set again in the cycle after that.
- R8: While `rst_n` is low and after it is released, bit 3 and `irq_out` are 0, `rdata` is zero and `err` is 0.
- R9: An access (read or write) to a word index above 3 makes `err` high for exactly the cycle after the access. A read of such a word returns zero.
- R10: Read data appears on `rdata` in the cycle after the read access and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel | input | 1 | Register access strobe, one cycle per access |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | ADDR_W (4) | Word index |
| wdata | input | DATA_W (32) | Write data |
| rdata | output | DATA_W (32) | Read data, registered |
| err | output | 1 | One-cycle pulse after an out-of-range access |
| wp_in | input | 1 | Write-protect switch level |
| card_in | input | 1 | Card-insert event input |
| irq_out | output | 1 | Interrupt request, set by an insertion |

## Verification
The hardest case to reach from the ports is a clearing write that lands while the insert input is still high. In that case the flag drops for one cycle and then sets again. The bench holds `card_in` high, issues the acknowledge write, and samples `irq_out` in the next two cycles to see the one-cycle dip. It also checks that a write with bit 3 clear leaves the flag alone. Finally, it checks that the write-protect bit read through word 2 follows `wp_in` after a write of all ones.

// File: rtl/cdi_pkg.sv
package cdi_pkg;
   localparam int NUM_WORDS = 4;

   typedef enum logic [1:0] {
      W_IDENT  = 2'd0,
      W_FLASH  = 2'd1,
      W_STATUS = 2'd2,
      W_DECODE = 2'd3
   } cdi_word_e;

   localparam logic [31:0] IDENT_WORD  = 32'h4103_4003;
   localparam logic [31:0] DECODE_WORD = 32'h0000_0011;
endpackage

// File: rtl/cdi_reg_decode.sv
module cdi_reg_decode #(
   parameter int ADDR_W = 4,
   parameter int WORDS  = cdi_pkg::NUM_WORDS
) (
   input  logic              sel,
   input  logic [ADDR_W-1:0] addr,
   output logic [WORDS-1:0]  hit,
   output logic              bad
);
   localparam logic [ADDR_W-1:0] LAST_IDX = ADDR_W'(WORDS - 1);

   if (ADDR_W < $clog2(WORDS)) begin : g_addr_chk
      $error("ADDR_W too narrow for the implemented words");
   end

   for (genvar i = 0; i < WORDS; i++) begin : g_hit
      assign hit[i] = sel && (addr == ADDR_W'(i));
   end

   if (ADDR_W > $clog2(WORDS)) begin : g_range
      assign bad = sel && (addr > LAST_IDX);
   end else begin : g_norange
      assign bad = 1'b0;
   end
endmodule

// File: rtl/cdi_insert_latch.sv
module cdi_insert_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic event_in,
   input  logic ack,
   output logic flag
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        flag <= 1'b0;
      else if (ack)      flag <= 1'b0;
      else if (event_in) flag <= 1'b1;
   end

   a_r4_sets_on_event: assert property (@(posedge clk) disable iff (!rst_n)
      (event_in && !ack) |=> flag);
   a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !ack) |=> flag);
   a_r5_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
      ack |=> !flag);
endmodule

// File: rtl/cdi_card_regs.sv
module cdi_card_regs #(
   parameter int          DATA_W   = 32,
   parameter int          ADDR_W   = 4,
   parameter int          WP_BIT   = 0,
   parameter int          INS_BIT  = 3,
   parameter bit          READ_REG = 1'b1,
   parameter logic [31:0] ID_VAL   = cdi_pkg::IDENT_WORD,
   parameter logic [31:0] DEC_VAL  = cdi_pkg::DECODE_WORD
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              err,
   input  logic              wp_in,
   input  logic              card_in,
   output logic              irq_out
);
   import cdi_pkg::*;

   localparam int WORDS = NUM_WORDS;

   if (DATA_W < 32) begin : g_width_chk
      $error("DATA_W must hold the 32-bit constant words");
   end
   if (INS_BIT >= DATA_W || WP_BIT >= DATA_W || INS_BIT == WP_BIT) begin : g_bit_chk
      $error("status bit positions invalid");
   end

   logic [WORDS-1:0]  hit;
   logic              bad;
   logic              ins_flag;
   logic              ack;
   logic [DATA_W-1:0] status_word;
   logic [DATA_W-1:0] rd_mux;
   logic              err_q;

   cdi_reg_decode #(.ADDR_W(ADDR_W), .WORDS(WORDS)) u_dec (
      .sel (sel),
      .addr(addr),
      .hit (hit),
      .bad (bad)
   );

   assign ack = wr && hit[W_STATUS] && wdata[INS_BIT];

   cdi_insert_latch u_latch (
      .clk     (clk),
      .rst_n   (rst_n),
      .event_in(card_in),
      .ack     (ack),
      .flag    (ins_flag)
   );

   always_comb begin
      status_word          = '0;
      status_word[WP_BIT]  = wp_in;
      status_word[INS_BIT] = ins_flag;
   end

   always_comb begin
      rd_mux = '0;
      unique case (1'b1)
         hit[W_IDENT]:  rd_mux = DATA_W'(ID_VAL);
         hit[W_STATUS]: rd_mux = status_word;
         hit[W_DECODE]: rd_mux = DATA_W'(DEC_VAL);
         default:       rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) err_q <= 1'b0;
      else        err_q <= bad;
   end
   assign err     = err_q;
   assign irq_out = ins_flag;

   if (READ_REG) begin : g_rd_reg
      logic [DATA_W-1:0] rd_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          rd_q <= '0;
         else if (sel && !wr) rd_q <= rd_mux;
      end
      assign rdata = rd_q;

      a_r2_flash_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
         (sel && !wr && addr == ADDR_W'(W_FLASH)) |=> (rdata == '0));
      a_r10_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n)
         !(sel && !wr) |=> $stable(rdata));
   end else begin : g_rd_comb
      assign rdata = (sel && !wr) ? rd_mux : '0;
   end

   a_r9_err_after_bad: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && addr > ADDR_W'(WORDS - 1)) |=> err);
   a_r9_err_only_bad: assert property (@(posedge clk) disable iff (!rst_n)
      !(sel && addr > ADDR_W'(WORDS - 1)) |=> !err);
   a_r6_irq_from_event: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_out) |-> $past(card_in));
   a_r5_irq_drops_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && wr && addr == ADDR_W'(W_STATUS) && wdata[INS_BIT]) |=> !irq_out);
endmodule

// File: tb/tb_cdi_card_regs.sv
module tb_cdi_card_regs;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sel = 1'b0, wr = 1'b0;
   logic [3:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        err;
   logic        wp_in = 1'b0, card_in = 1'b0;
   logic        irq_out;

   int checks = 0, fails = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   cdi_card_regs dut (
      .clk(clk), .rst_n(rst_n), .sel(sel), .wr(wr), .addr(addr),
      .wdata(wdata), .rdata(rdata), .err(err), .wp_in(wp_in),
      .card_in(card_in), .irq_out(irq_out)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // one access; returns at the negedge after the capturing edge
   task automatic acc(input bit w, input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      sel = 1'b1; wr = w; addr = a; wdata = d;
      @(negedge clk);
      sel = 1'b0; wr = 1'b0; wdata = '0;
   endtask

   // {wr, addr, wdata, wp, exp_rdata, exp_err}
   localparam int NV = 17;
   localparam logic [70:0] VEC [NV] = '{
      {1'b0, 4'd0,  32'h0,        1'b0, 32'h41034003, 1'b0},
      {1'b0, 4'd3,  32'h0,        1'b0, 32'h00000011, 1'b0},
      {1'b0, 4'd1,  32'h0,        1'b0, 32'h00000000, 1'b0},
      {1'b1, 4'd1,  32'hffffffff, 1'b0, 32'h0,        1'b0},
      {1'b0, 4'd1,  32'h0,        1'b0, 32'h00000000, 1'b0},
      {1'b1, 4'd3,  32'h0,        1'b0, 32'h0,        1'b0},
      {1'b1, 4'd0,  32'hffffffff, 1'b0, 32'h0,        1'b0},
      {1'b0, 4'd0,  32'h0,        1'b0, 32'h41034003, 1'b0},
      {1'b0, 4'd3,  32'h0,        1'b0, 32'h00000011, 1'b0},
      {1'b0, 4'd2,  32'h0,        1'b1, 32'h00000001, 1'b0},
      {1'b0, 4'd2,  32'h0,        1'b0, 32'h00000000, 1'b0},
      {1'b1, 4'd2,  32'hffffffff, 1'b1, 32'h0,        1'b0},
      {1'b0, 4'd2,  32'h0,        1'b1, 32'h00000001, 1'b0},
      {1'b1, 4'd2,  32'hfffffff6, 1'b0, 32'h0,        1'b0},
      {1'b0, 4'd5,  32'h0,        1'b0, 32'h00000000, 1'b1},
      {1'b1, 4'd15, 32'h12345678, 1'b0, 32'h0,        1'b1},
      {1'b0, 4'd4,  32'h0,        1'b0, 32'h00000000, 1'b1}
   };

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      // R8: reset state
      repeat (3) @(negedge clk);
      chk(irq_out == 1'b0, "R8 irq in reset", 32'(irq_out), 0);
      chk(rdata == '0, "R8 rdata in reset", rdata, 0);
      chk(err == 1'b0, "R8 err in reset", 32'(err), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(irq_out == 1'b0, "R8 irq after reset", 32'(irq_out), 0);

      for (int i = 0; i < NV; i++) begin
         logic [70:0] v;
         string tag;
         v = VEC[i];
         wp_in = v[33];
         tag = (v[69:66] > 4'd3) ? "R9" : (v[69:66] == 4'd2) ? "R3" :
               (v[69:66] == 4'd1) ? "R2" : "R1";
         acc(v[70], v[69:66], v[65:34]);
         if (!v[70]) chk(rdata == v[32:1], tag, rdata, v[32:1]);
         chk(err == v[0], tag, 32'(err), 32'(v[0]));
         chk(irq_out == 1'b0, "R2 no side effect on irq", 32'(irq_out), 0);
      end
      wp_in = 1'b0;

      // R9: err lasts one cycle
      acc(1'b0, 4'd9, 0);
      chk(err == 1'b1, "R9 err pulse", 32'(err), 1);
      @(negedge clk);
      chk(err == 1'b0, "R9 err one cycle", 32'(err), 0);

      // R4/R6: insertion latches and stays
      card_in = 1'b1;
      @(negedge clk);
      card_in = 1'b0;
      chk(irq_out == 1'b1, "R6 irq after insert", 32'(irq_out), 1);
      repeat (5) @(negedge clk);
      chk(irq_out == 1'b1, "R4 sticky", 32'(irq_out), 1);
      acc(1'b0, 4'd2, 0);
      chk(rdata == 32'h8, "R4 status bit3", rdata, 32'h8);

      // R5: write without bit 3 leaves flag; R10 rdata holds across writes
      acc(1'b1, 4'd2, 32'hfffffff7);
      chk(irq_out == 1'b1, "R5 no clear without bit3", 32'(irq_out), 1);
      chk(rdata == 32'h8, "R10 rdata holds", rdata, 32'h8);
      wp_in = 1'b1;
      acc(1'b0, 4'd2, 0);
      chk(rdata == 32'h9, "R6 status both bits", rdata, 32'h9);
      acc(1'b1, 4'd2, 32'h8);
      chk(irq_out == 1'b0, "R5 clear", 32'(irq_out), 0);
      acc(1'b0, 4'd2, 0);
      chk(rdata == 32'h1, "R5 cleared read", rdata, 32'h1);
      wp_in = 1'b0;

      // R7: clear while insert held high
      card_in = 1'b1;
      @(negedge clk);
      chk(irq_out == 1'b1, "R7 set", 32'(irq_out), 1);
      acc(1'b1, 4'd2, 32'h8);
      chk(irq_out == 1'b0, "R7 dip", 32'(irq_out), 0);
      @(negedge clk);
      chk(irq_out == 1'b1, "R7 reset again", 32'(irq_out), 1);
      card_in = 1'b0;
      acc(1'b1, 4'd2, 32'h8);
      @(negedge clk);
      chk(irq_out == 1'b0, "R5 clear after drop", 32'(irq_out), 0);

      // R8: reset clears a set flag
      card_in = 1'b1;
      @(negedge clk);
      card_in = 1'b0;
      acc(1'b0, 4'd0, 0);
      rst_n = 1'b0;
      @(negedge clk);
      chk(irq_out == 1'b0, "R8 flag reset", 32'(irq_out), 0);
      chk(rdata == '0, "R8 rdata reset", rdata, 0);
      rst_n = 1'b1;
      @(negedge clk);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule